// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits between a set of peripheral interrupt flags and a small 8-bit CPU core. Each source has a latched pending flag, an enable bit and a two-bit priority. Every cycle the arbiter picks one winner among the enabled pending sources. The highest level wins. Within a level, a fixed source ranking breaks ties. The arbiter drives the winner's vector address toward the core and raises a request when nesting rules allow it.

Nesting uses one in-service bit per level. An acknowledge from the core sets the bit for the granted level. A return-from-interrupt pulse clears the highest bit that is set. A request is only raised for a level strictly above every level currently in service. After an acknowledge, the vector is frozen until the core reports that it has latched the address.

Some sources have their flag cleared automatically when they are vectored. Others need a software clear. A separate wake output reports enabled pending sources that may bring the core out of power-down.

Top module: `irq_nest_arb`

## Requirements
- R1: A source's level is {prio_hi, prio_lo}: 00 is level 0 (lowest) up to 11 is level 3 (highest). Among enabled pending sources, one of a higher level always wins over one of a lower level, whatever their ranking.
- R2: Among enabled pending sources of equal level, the lowest source index wins. The ranking order is index 0 external 0, 1 brownout, 2 watchdog, 3 timer 0, 4 I2C, 5 ADC, then indices 6 and up.
- R3: irq_vec carries the winner's vector. The vectors are index 0 0x0003, 1 0x002B, 2 0x0053, 3 0x000B, 4 0x0033 and 5 0x005B. Index i from 6 upward uses 0x0063 + 8*(i-6). irq_vec is 0 when nothing enabled is pending.
- R4: irq_req is high only when glb_en is 1, an enabled source is pending, and the winner's level is strictly above the highest level in service. A source whose src_en bit is 0 takes no part in arbitration.
- R5: While level 3 is in service, irq_req stays low for any source.
- R6: When cpu_ack is high with irq_req high, the in-service bit of the winner's level is set in svc_lvls (bit n = level n). A cpu_reti pulse clears the highest set bit of svc_lvls.
- R7: A src_set pulse latches the source's pending flag. The flag stays set until it is cleared. An acknowledged grant clears the flag of index 0 and of index 3 in hardware. It clears no other flag.
- R8: A sw_clr pulse clears the pending flag of any source except index 0. For index 0, sw_clr has no effect.
- R9: wake is high whenever an enabled pending source is one of index 0, 1 or 5. This holds regardless of glb_en and of the in-service state.
- R10: From an acknowledge until a vec_taken pulse, irq_vec holds the vector granted at the acknowledge, and irq_req stays low.
- R11: After reset, no flag is pending, svc_lvls is 0000, irq_req is 0, irq_vec is 0 and wake is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_set | input | NSRC | One-cycle flag-set pulse per source |
| sw_clr | input | NSRC | One-cycle software flag clear per source |
| src_en | input | NSRC | Per-source enable |
| prio_hi | input | NSRC | Upper priority bit per source |
| prio_lo | input | NSRC | Lower priority bit per source |
| cpu_ack | input | 1 | Core accepts the current request |
| cpu_reti | input | 1 | Core returns from the current routine |
| vec_taken | input | 1 | Core has latched the vector |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the winner or of the held grant |
| svc_lvls | output | 4 | In-service bit per level |
| wake | output | 1 | Power-down wake indication |

## Verification
The properties assume that cpu_ack and cpu_reti never arrive in the same cycle. They also assume that the core pulses vec_taken only after an acknowledge, and that cpu_reti comes only while some level is in service. The bench drives every control pulse for exactly one cycle and acknowledges only while irq_req is high. It returns only as many times as it has acknowledged, and always issues vec_taken before the next acknowledge. Priority and enable changes are applied between clock edges, so the combinational winner is sampled after it settles.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and per-source property functions for the nested
// interrupt arbiter. Assumes the ranking is the source index (0 highest).
package irq_pkg;
    localparam int LVL_W = 2;
    localparam int NLVL  = 1 << LVL_W;
    localparam int VEC_W = 16;

    // Vector address of a source index.
    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        case (idx)
            0:       vec_of = 16'h0003;
            1:       vec_of = 16'h002B;
            2:       vec_of = 16'h0053;
            3:       vec_of = 16'h000B;
            4:       vec_of = 16'h0033;
            5:       vec_of = 16'h005B;
            default: vec_of = 16'h0063 + VEC_W'((idx - 6) * 8);
        endcase
    endfunction

    // Source may wake the core from power-down.
    function automatic bit wake_ok(input int idx);
        wake_ok = (idx == 0) || (idx == 1) || (idx == 5);
    endfunction

    // Flag cleared by hardware when the grant is acknowledged.
    function automatic bit hw_clr_ok(input int idx);
        hw_clr_ok = (idx == 0) || (idx == 3);
    endfunction

    // Flag may be cleared by software.
    function automatic bit sw_clr_ok(input int idx);
        sw_clr_ok = (idx != 0);
    endfunction
endpackage

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
// Pending flag register per source. A set pulse wins over any clear in the
// same cycle. Hardware and software clear rights are fixed per index.
module irq_flags #(
    parameter int NSRC = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] sw_clr_i,
    input  logic [NSRC-1:0] grant_clr_i,
    output logic [NSRC-1:0] flag_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        localparam bit HW = irq_pkg::hw_clr_ok(i);
        localparam bit SW = irq_pkg::sw_clr_ok(i);
        logic kill;
        // Combine the clear sources this index honours.
        always_comb kill = (HW && grant_clr_i[i]) || (SW && sw_clr_i[i]);
        // Latch, hold or drop the pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (kill)     flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
// Combinational winner selection: highest level first, then lowest index.
// Assumes pend_i already has disabled sources masked off.
module irq_pick #(
    parameter int NSRC = 13
) (
    input  logic [NSRC-1:0]            pend_i,
    input  logic [NSRC-1:0]            prio_hi_i,
    input  logic [NSRC-1:0]            prio_lo_i,
    output logic                       any_o,
    output logic [irq_pkg::LVL_W-1:0]  lvl_o,
    output logic [NSRC-1:0]            win_oh_o,
    output logic [irq_pkg::VEC_W-1:0]  vec_o
);
    localparam int LVL_W = irq_pkg::LVL_W;
    localparam int NLVL  = irq_pkg::NLVL;
    localparam int VEC_W = irq_pkg::VEC_W;

    logic [NLVL-1:0][NSRC-1:0] lvl_pend;
    logic [VEC_W-1:0]          vtab [NSRC];
    logic [NSRC-1:0]           sel;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            // Source i pending at level l.
            assign lvl_pend[l][i] = pend_i[i] && ({prio_hi_i[i], prio_lo_i[i]} == LVL_W'(l));
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_vtab
        assign vtab[i] = irq_pkg::vec_of(i);
    end

    // Find the highest level that has any pending source.
    always_comb begin
        any_o = 1'b0;
        lvl_o = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (|lvl_pend[l]) begin
                any_o = 1'b1;
                lvl_o = LVL_W'(l);
            end
        end
    end

    // Isolate the lowest-index pending source at the winning level.
    always_comb begin
        sel      = lvl_pend[lvl_o];
        win_oh_o = sel & (~sel + {{(NSRC-1){1'b0}}, 1'b1});
    end

    // Select the vector of the one-hot winner.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win_oh_o[i]) vec_o = vec_o | vtab[i];
        end
    end
endmodule

// File: rtl/irq_svc.sv
`timescale 1ns/1ps
// In-service level record and vector hold. Assumes take and reti never
// coincide and that reti only arrives while some level is in service.
module irq_svc (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take_i,
    input  logic [irq_pkg::LVL_W-1:0] take_lvl_i,
    input  logic                      reti_i,
    input  logic                      taken_i,
    input  logic [irq_pkg::VEC_W-1:0] live_vec_i,
    output logic [irq_pkg::NLVL-1:0]  svc_o,
    output logic [irq_pkg::LVL_W:0]   ceil_o,
    output logic                      hold_o,
    output logic [irq_pkg::VEC_W-1:0] vec_o
);
    localparam int LVL_W = irq_pkg::LVL_W;
    localparam int NLVL  = irq_pkg::NLVL;
    localparam int VEC_W = irq_pkg::VEC_W;

    logic [LVL_W-1:0] top_idx;
    logic [NLVL-1:0]  svc_nx;
    logic [VEC_W-1:0] held_vec;

    // Locate the highest level in service.
    always_comb begin
        top_idx = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (svc_o[l]) top_idx = LVL_W'(l);
        end
        ceil_o = (svc_o == '0) ? '0 : ({1'b0, top_idx} + {{LVL_W{1'b0}}, 1'b1});
    end

    // Next in-service vector after return and grant.
    always_comb begin
        svc_nx = svc_o;
        if (reti_i && (svc_o != '0)) svc_nx[top_idx] = 1'b0;
        if (take_i) svc_nx[take_lvl_i] = 1'b1;
    end

    // Register the in-service record.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_o <= '0;
        else        svc_o <= svc_nx;
    end

    // Freeze the granted vector until the core reports it latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_o   <= 1'b0;
            held_vec <= '0;
        end else if (take_i) begin
            hold_o   <= 1'b1;
            held_vec <= live_vec_i;
        end else if (taken_i) begin
            hold_o   <= 1'b0;
        end
    end

    // Present the held or the live vector.
    always_comb vec_o = hold_o ? held_vec : live_vec_i;
endmodule

// File: rtl/irq_nest_arb.sv
`timescale 1ns/1ps
// Four-level nested interrupt arbiter top. Assumes src_set, sw_clr and the
// core pulses are synchronous to clk and one cycle wide.
module irq_nest_arb #(
    parameter int NSRC = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glb_en,
    input  logic [NSRC-1:0]          src_set,
    input  logic [NSRC-1:0]          sw_clr,
    input  logic [NSRC-1:0]          src_en,
    input  logic [NSRC-1:0]          prio_hi,
    input  logic [NSRC-1:0]          prio_lo,
    input  logic                     cpu_ack,
    input  logic                     cpu_reti,
    input  logic                     vec_taken,
    output logic                     irq_req,
    output logic [irq_pkg::VEC_W-1:0] irq_vec,
    output logic [irq_pkg::NLVL-1:0] svc_lvls,
    output logic                     wake
);
    localparam int LVL_W = irq_pkg::LVL_W;
    localparam int VEC_W = irq_pkg::VEC_W;

    logic [NSRC-1:0]  flags, pend, win_oh, grant_clr, wake_mask;
    logic             any_pend, take, hold;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W:0]   ceil, win_rank;
    logic [VEC_W-1:0] live_vec;

    for (genvar i = 0; i < NSRC; i++) begin : g_wmask
        assign wake_mask[i] = irq_pkg::wake_ok(i);
    end

    irq_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .sw_clr_i(sw_clr),
        .grant_clr_i(grant_clr), .flag_o(flags)
    );

    irq_pick #(.NSRC(NSRC)) u_pick (
        .pend_i(pend), .prio_hi_i(prio_hi), .prio_lo_i(prio_lo),
        .any_o(any_pend), .lvl_o(win_lvl), .win_oh_o(win_oh), .vec_o(live_vec)
    );

    irq_svc u_svc (
        .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(win_lvl),
        .reti_i(cpu_reti), .taken_i(vec_taken), .live_vec_i(live_vec),
        .svc_o(svc_lvls), .ceil_o(ceil), .hold_o(hold), .vec_o(irq_vec)
    );

    // Mask disabled sources and build the wake indication.
    always_comb begin
        pend = flags & src_en;
        wake = |(pend & wake_mask);
    end

    // Request only above the in-service ceiling and outside a vector hold.
    always_comb begin
        win_rank  = {1'b0, win_lvl} + {{LVL_W{1'b0}}, 1'b1};
        irq_req   = glb_en && any_pend && !hold && (win_rank > ceil);
        take      = cpu_ack && irq_req;
        grant_clr = win_oh & {NSRC{take}};
    end
endmodule

// File: rtl/irq_nest_arb_chk.sv
`timescale 1ns/1ps
// Property checker for irq_nest_arb, attached by bind.
module irq_nest_arb_chk #(
    parameter int NSRC = 13
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      glb_en,
    input logic [NSRC-1:0]           src_en,
    input logic                      cpu_ack,
    input logic                      cpu_reti,
    input logic                      vec_taken,
    input logic                      irq_req,
    input logic [irq_pkg::VEC_W-1:0] irq_vec,
    input logic [irq_pkg::NLVL-1:0]  svc_lvls,
    input logic                      wake
);
    logic hold_t;

    // Track the window between a grant and the vector being latched.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hold_t <= 1'b0;
        else if (cpu_ack && irq_req)  hold_t <= 1'b1;
        else if (vec_taken)           hold_t <= 1'b0;
    end

    AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n) !glb_en |-> !irq_req); // R4
    AST_NO_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (src_en == '0) |-> (!irq_req && !wake)); // R9
    AST_TOP_LVL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) svc_lvls[irq_pkg::NLVL-1] |-> !irq_req); // R5
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ack && irq_req && !cpu_reti) |=> ($countones(svc_lvls) == $countones($past(svc_lvls)) + 1)); // R6
    AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n) (cpu_reti && !cpu_ack && svc_lvls != '0) |=> ($countones(svc_lvls) + 1 == $countones($past(svc_lvls)))); // R6
    AST_VEC_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (cpu_ack && irq_req) |=> (irq_vec == $past(irq_vec))); // R10
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (hold_t && !vec_taken) |=> $stable(irq_vec)); // R10
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hold_t |-> !irq_req); // R10
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .vec_taken(vec_taken),
    .irq_req(irq_req), .irq_vec(irq_vec), .svc_lvls(svc_lvls), .wake(wake)
);

// File: tb/irq_nest_arb_tb.sv
`timescale 1ns/1ps
module irq_nest_arb_tb;
    localparam int NSRC = 13;

    typedef struct packed {
        logic        req;
        logic [15:0] vec;
        logic [3:0]  svc;
        logic        wake;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, glb_en = 1'b1;
    logic [NSRC-1:0] src_set = '0, sw_clr = '0, src_en = '1, prio_hi = '0, prio_lo = '0;
    logic cpu_ack = 1'b0, cpu_reti = 1'b0, vec_taken = 1'b0;
    logic irq_req, wake;
    logic [15:0] irq_vec;
    logic [3:0]  svc_lvls;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    irq_nest_arb #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_set(src_set),
        .sw_clr(sw_clr), .src_en(src_en), .prio_hi(prio_hi), .prio_lo(prio_lo),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .vec_taken(vec_taken),
        .irq_req(irq_req), .irq_vec(irq_vec), .svc_lvls(svc_lvls), .wake(wake)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver side: push the expected outputs and wake the monitor.
    task automatic expect_out(string tag, logic req, logic [15:0] vec, logic [3:0] svc, logic wk);
        exp_t e;
        #0.1;
        e = '{req: req, vec: vec, svc: svc, wake: wk};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> chk_ev;
        #0.1;
    endtask

    task automatic set_lvl(int idx, int lvl);
        prio_hi[idx] = lvl[1];
        prio_lo[idx] = lvl[0];
    endtask

    task automatic pulse_set(logic [NSRC-1:0] m);
        src_set = m; step(); src_set = '0;
    endtask

    task automatic pulse_clr(logic [NSRC-1:0] m);
        sw_clr = m; step(); sw_clr = '0;
    endtask

    task automatic pulse_ack();
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        cpu_reti = 1'b1; step(); cpu_reti = 1'b0;
    endtask

    task automatic pulse_taken();
        vec_taken = 1'b1; step(); vec_taken = 1'b0;
    endtask

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (irq_req !== e.req || irq_vec !== e.vec || svc_lvls !== e.svc || wake !== e.wake) begin
                    errors++;
                    $display("FAIL %s: actual req=%0b vec=%h svc=%b wake=%0b expected req=%0b vec=%h svc=%b wake=%0b",
                             t, irq_req, irq_vec, svc_lvls, wake, e.req, e.vec, e.svc, e.wake);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        expect_out("R11 reset state", 0, 16'h0000, 4'b0000, 0);

        pulse_set(13'h000C);
        expect_out("R2 watchdog ranks over timer0", 1, 16'h0053, 4'b0000, 0);
        set_lvl(3, 2);
        expect_out("R1 higher level timer0 wins", 1, 16'h000B, 4'b0000, 0);

        pulse_ack();
        expect_out("R6 ack sets level 2, R10 vector held", 0, 16'h000B, 4'b0100, 0);
        step();
        expect_out("R10 vector still held", 0, 16'h000B, 4'b0100, 0);
        pulse_taken();
        expect_out("R7 timer0 hw cleared, R4 level0 below ceiling", 0, 16'h0053, 4'b0100, 0);

        set_lvl(2, 2);
        expect_out("R4 same level not requested", 0, 16'h0053, 4'b0100, 0);
        set_lvl(2, 3);
        expect_out("R4 higher level requested", 1, 16'h0053, 4'b0100, 0);
        pulse_ack();
        pulse_taken();
        expect_out("R7 watchdog stays pending after ack", 0, 16'h0053, 4'b1100, 0);

        set_lvl(0, 3);
        pulse_set(13'h0001);
        expect_out("R5 level 3 blocks, R9 ext0 wakes", 0, 16'h0003, 4'b1100, 1);
        pulse_clr(13'h0001);
        expect_out("R8 sw clear ignored on index 0", 0, 16'h0003, 4'b1100, 1);
        pulse_clr(13'h0004);

        pulse_reti();
        expect_out("R6 reti pops level 3", 1, 16'h0003, 4'b0100, 1);
        glb_en = 1'b0;
        expect_out("R4 global disable, R9 wake kept", 0, 16'h0003, 4'b0100, 1);
        glb_en = 1'b1;
        pulse_ack();
        expect_out("R7 ext0 hw cleared on ack", 0, 16'h0003, 4'b1100, 0);
        pulse_taken();
        expect_out("R8 watchdog sw cleared", 0, 16'h0000, 4'b1100, 0);
        pulse_reti();
        pulse_reti();
        expect_out("R6 all levels returned", 0, 16'h0000, 4'b0000, 0);

        prio_hi = '0; prio_lo = '0;
        pulse_set(13'h1040);
        expect_out("R2 index 6 over index 12", 1, 16'h0063, 4'b0000, 0);
        pulse_clr(13'h0040);
        expect_out("R3 index 12 vector", 1, 16'h0093, 4'b0000, 0);
        pulse_clr(13'h1000);

        src_en[5] = 1'b0;
        pulse_set(13'h0020);
        expect_out("R4 disabled source ignored", 0, 16'h0000, 4'b0000, 0);
        src_en[5] = 1'b1;
        expect_out("R3 ADC vector, R9 ADC wakes", 1, 16'h005B, 4'b0000, 1);
        pulse_set(13'h0002);
        expect_out("R3 brownout vector, R2 rank", 1, 16'h002B, 4'b0000, 1);
        pulse_clr(13'h0022);
        pulse_set(13'h0010);
        expect_out("R3 I2C vector, R9 no wake", 1, 16'h0033, 4'b0000, 0);
        pulse_clr(13'h0010);

        pulse_set(13'h0008);
        expect_out("R3 timer0 vector", 1, 16'h000B, 4'b0000, 0);
        pulse_clr(13'h0008);
        expect_out("R8 timer0 sw cleared", 0, 16'h0000, 4'b0000, 0);

        set_lvl(5, 1);
        pulse_set(13'h0021);
        expect_out("R1 level 1 ADC over level 0 ext0", 1, 16'h005B, 4'b0000, 1);

        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule